// File: doc/BRIEF.md
# Next-PC and Exception Control Unit

This unit sits beside the execute stage of a 32-bit in-order core. For every valid instruction it works out the address of the next instruction to fetch, decides whether the instruction writes a return-address register, and maintains a three-bit interrupt-enable state. It covers conditional branches on two register operands, relative jumps and calls, jumps and calls through a register, the two exception-return forms, the system-call and debug-break traps, and three exception sources that come from outside the instruction: a divide-by-zero flag, an external interrupt request and a misaligned program counter.

The next PC, the link write and the exception outputs are combinational from the current inputs. Only the interrupt-enable state is held in a register. A separate CSR write port can load that state. Such a write counts as having happened before the instruction in the same cycle, so that instruction acts on the written value. Exceptions vector to an exception base address taken from an input, plus a fixed spacing of 2^VEC_SHIFT bytes per cause code.

Top module: `npc_exc_unit`

## Requirements
- R1: The major opcode is instr[31:26]. Opcodes 17 (equal), 18 (signed greater), 19 (signed greater-or-equal), 20 (unsigned greater-or-equal), 21 (unsigned greater) and 23 (not equal) compare opA against opB. opA is the register in instr[25:21] and opB is the register in instr[20:16]. When the condition holds, nextPc = pc + (sign-extended instr[15:0] << 2). Otherwise nextPc = pc + 4.
- R2: Opcode 56 (relative jump) sets nextPc = pc + (sign-extended instr[25:0] << 2) and writes no link register.
- R3: Opcode 62 (relative call) targets the same address as R2. Opcode 54 (register call) targets opA. Both calls write pc + 4 into register 29.
- R4: Opcode 48 (register jump) sets nextPc = opA. If instr[25:21] is 30, IE bit 0 takes the value of bit 1. If instr[25:21] is 31, IE bit 0 takes the value of bit 2. The other IE bits are unchanged.
- R5: Opcode 43 is a trap. instr[4:0] = 7 raises a system call (cause 2) and instr[4:0] = 2 raises a debug break (cause 3). Any other value raises an illegal-trap exception (cause 5). Every exception sets nextPc = excBase + (cause << VEC_SHIFT), with VEC_SHIFT = 5 by default.
- R6: A taken exception writes pc, the address of the instruction that caused it, into register 30. It copies IE bit 0 into IE bit 1 and clears IE bit 0. A debug break uses register 31 and IE bit 2 instead.
- R7: divZero raised with a valid instruction gives exception cause 4. The saved PC is the address of that instruction.
- R8: irqReq gives exception cause 1 only when IE bit 0 is 1. The interrupted instruction has no effect of its own, and its address is the saved PC.
- R9: A valid instruction with pc[1:0] not equal to 0 gives exception cause 6 whatever else is present.
- R10: When several exception sources are present together, the order of precedence is misaligned PC, then illegal trap, then divide-by-zero, then system call or break, then interrupt.
- R11: A CSR write (csrIeWrEn) loads csrIeWrData into IE at the clock edge. An instruction or interrupt check in the same cycle uses the written value as its starting IE.
- R12: Any other opcode gives nextPc = pc + 4 with no link write. With instrValid low, nextPc = pc, no link write and no exception are produced, and IE changes only through the CSR port.
- R13: Reset clears IE to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | An instruction is presented this cycle |
| pc | input | XLEN | Address of the current instruction |
| instr | input | 32 | Instruction word |
| opA | input | XLEN | Value of the register named by instr[25:21] |
| opB | input | XLEN | Value of the register named by instr[20:16] |
| excBase | input | XLEN | Exception base address |
| irqReq | input | 1 | External interrupt request |
| divZero | input | 1 | Divider reports a zero divisor for this instruction |
| csrIeWrEn | input | 1 | CSR write to the IE state |
| csrIeWrData | input | 3 | Value written to IE |
| nextPc | output | XLEN | Address of the next instruction |
| linkWrEn | output | 1 | Register write for link or saved PC |
| linkIdx | output | 5 | Index of the register written |
| linkData | output | XLEN | Value written |
| ieState | output | 3 | IE state: bit 0 global enable, bit 1 saved on exception, bit 2 saved on break |
| excTaken | output | 1 | An exception is taken this cycle |
| excCause | output | 3 | Cause code of the exception taken (0 when none) |

## Verification
Two events can fall in the same cycle and must be judged together: a CSR write to IE, and an instruction that reads or changes IE. The cases are an exception return, a trap, and an interrupt check gated by IE bit 0. The bench forces the two together in directed cases, for example a CSR write that sets only the saved bit while an exception return executes, and a CSR write that enables interrupts while irqReq is high. It also lets random stimulus overlap them often. A bench model applies the CSR value first and the instruction's effect on top, and predicts both the combinational outputs and the IE value after the edge.

// File: rtl/npc_exc_pkg.sv
package npc_exc_pkg;

  localparam logic [5:0] OP_BEQ   = 6'd17;
  localparam logic [5:0] OP_BGTS  = 6'd18;
  localparam logic [5:0] OP_BGES  = 6'd19;
  localparam logic [5:0] OP_BGEU  = 6'd20;
  localparam logic [5:0] OP_BGTU  = 6'd21;
  localparam logic [5:0] OP_BNEQ  = 6'd23;
  localparam logic [5:0] OP_TRAP  = 6'd43;
  localparam logic [5:0] OP_JREG  = 6'd48;
  localparam logic [5:0] OP_CREG  = 6'd54;
  localparam logic [5:0] OP_JREL  = 6'd56;
  localparam logic [5:0] OP_CREL  = 6'd62;

  localparam logic [4:0] IDX_RET  = 5'd29;
  localparam logic [4:0] IDX_EPC  = 5'd30;
  localparam logic [4:0] IDX_BPC  = 5'd31;

  localparam logic [4:0] TRAP_SYS = 5'd7;
  localparam logic [4:0] TRAP_BRK = 5'd2;

  localparam int IE_GLOBAL = 0;
  localparam int IE_SAVEXC = 1;
  localparam int IE_SAVBRK = 2;

  typedef enum logic [2:0] {
    CZ_NONE = 3'd0, CZ_IRQ = 3'd1, CZ_SYSCALL = 3'd2, CZ_BREAK = 3'd3,
    CZ_DIVZERO = 3'd4, CZ_ILLEGAL = 3'd5, CZ_MISALIGN = 3'd6
  } cause_e;

  typedef enum logic [2:0] {
    PS_HOLD, PS_SEQ, PS_COND, PS_REL26, PS_REG, PS_VEC
  } pcSel_e;

  typedef enum logic [2:0] {
    CMP_EQ, CMP_GTS, CMP_GES, CMP_GEU, CMP_GTU, CMP_NE
  } cmp_e;

  typedef enum logic [1:0] { LK_NONE, LK_RET, LK_EPC } link_e;

  typedef struct packed {
    pcSel_e     pcSel;
    cmp_e       cmpOp;
    link_e      linkSel;
    logic [4:0] linkIdx;
    cause_e     cause;
  } strobe_t;

endpackage

// File: rtl/npc_exc_ctrl.sv
module npc_exc_ctrl
  import npc_exc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instrValid,
  input  logic [5:0] opcode,
  input  logic [4:0] rsIdx,
  input  logic [4:0] trapCode,
  input  logic [1:0] pcLow,
  input  logic       irqReq,
  input  logic       divZero,
  input  logic       csrIeWrEn,
  input  logic [2:0] csrIeWrData,
  output strobe_t    strobe,
  output logic [2:0] ieState,
  output logic       excTaken,
  output cause_e     excCause
);

  typedef enum logic [2:0] {
    IEOP_KEEP, IEOP_RET_EXC, IEOP_RET_BRK, IEOP_TRAP_EXC, IEOP_TRAP_BRK
  } ieOp_e;

  logic [2:0] ieReg;
  logic [2:0] ieEff;
  logic [2:0] ieNext;
  logic       isTrap;
  cause_e     trapCause;
  cause_e     cause;
  ieOp_e      ieOp;
  strobe_t    instrStrobe;
  ieOp_e      instrIeOp;

  assign ieEff  = csrIeWrEn ? csrIeWrData : ieReg;
  assign isTrap = (opcode == OP_TRAP);

  always_comb begin
    if (trapCode == TRAP_SYS)      trapCause = CZ_SYSCALL;
    else if (trapCode == TRAP_BRK) trapCause = CZ_BREAK;
    else                           trapCause = CZ_ILLEGAL;
  end

  // Exception precedence chain
  always_comb begin
    if (!instrValid)                          cause = CZ_NONE;
    else if (pcLow != 2'b00)                  cause = CZ_MISALIGN;
    else if (isTrap && trapCause == CZ_ILLEGAL) cause = CZ_ILLEGAL;
    else if (divZero)                         cause = CZ_DIVZERO;
    else if (isTrap)                          cause = trapCause;
    else if (irqReq && ieEff[IE_GLOBAL])      cause = CZ_IRQ;
    else                                      cause = CZ_NONE;
  end

  // Normal flow decode
  always_comb begin
    instrStrobe.pcSel   = PS_SEQ;
    instrStrobe.cmpOp   = CMP_EQ;
    instrStrobe.linkSel = LK_NONE;
    instrStrobe.linkIdx = IDX_RET;
    instrStrobe.cause   = CZ_NONE;
    instrIeOp           = IEOP_KEEP;
    unique case (opcode)
      OP_BEQ:  begin instrStrobe.pcSel = PS_COND; instrStrobe.cmpOp = CMP_EQ;  end
      OP_BGTS: begin instrStrobe.pcSel = PS_COND; instrStrobe.cmpOp = CMP_GTS; end
      OP_BGES: begin instrStrobe.pcSel = PS_COND; instrStrobe.cmpOp = CMP_GES; end
      OP_BGEU: begin instrStrobe.pcSel = PS_COND; instrStrobe.cmpOp = CMP_GEU; end
      OP_BGTU: begin instrStrobe.pcSel = PS_COND; instrStrobe.cmpOp = CMP_GTU; end
      OP_BNEQ: begin instrStrobe.pcSel = PS_COND; instrStrobe.cmpOp = CMP_NE;  end
      OP_JREL: instrStrobe.pcSel = PS_REL26;
      OP_CREL: begin
        instrStrobe.pcSel   = PS_REL26;
        instrStrobe.linkSel = LK_RET;
      end
      OP_CREG: begin
        instrStrobe.pcSel   = PS_REG;
        instrStrobe.linkSel = LK_RET;
      end
      OP_JREG: begin
        instrStrobe.pcSel = PS_REG;
        if (rsIdx == IDX_EPC)      instrIeOp = IEOP_RET_EXC;
        else if (rsIdx == IDX_BPC) instrIeOp = IEOP_RET_BRK;
      end
      default: ;
    endcase
  end

  // Merge exception and normal flow into the strobe bundle
  always_comb begin
    if (!instrValid) begin
      strobe         = instrStrobe;
      strobe.pcSel   = PS_HOLD;
      strobe.linkSel = LK_NONE;
      ieOp           = IEOP_KEEP;
    end else if (cause != CZ_NONE) begin
      strobe.pcSel   = PS_VEC;
      strobe.cmpOp   = CMP_EQ;
      strobe.linkSel = LK_EPC;
      strobe.linkIdx = (cause == CZ_BREAK) ? IDX_BPC : IDX_EPC;
      strobe.cause   = cause;
      ieOp           = (cause == CZ_BREAK) ? IEOP_TRAP_BRK : IEOP_TRAP_EXC;
    end else begin
      strobe = instrStrobe;
      ieOp   = instrIeOp;
    end
  end

  always_comb begin
    ieNext = ieEff;
    unique case (ieOp)
      IEOP_RET_EXC:  ieNext[IE_GLOBAL] = ieEff[IE_SAVEXC];
      IEOP_RET_BRK:  ieNext[IE_GLOBAL] = ieEff[IE_SAVBRK];
      IEOP_TRAP_EXC: begin
        ieNext[IE_SAVEXC] = ieEff[IE_GLOBAL];
        ieNext[IE_GLOBAL] = 1'b0;
      end
      IEOP_TRAP_BRK: begin
        ieNext[IE_SAVBRK] = ieEff[IE_GLOBAL];
        ieNext[IE_GLOBAL] = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ieReg <= 3'b000;
    else        ieReg <= ieNext;
  end

  assign ieState  = ieReg;
  assign excTaken = (cause != CZ_NONE);
  assign excCause = cause;

endmodule

// File: rtl/npc_exc_dpath.sv
module npc_exc_dpath
  import npc_exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VEC_SHIFT = 5
) (
  input  logic [XLEN-1:0] pc,
  input  logic [25:0]     immField,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] excBase,
  input  strobe_t         strobe,
  output logic [XLEN-1:0] nextPc,
  output logic            linkWrEn,
  output logic [4:0]      linkIdx,
  output logic [XLEN-1:0] linkData
);

  localparam int OFF16_W = 18;
  localparam int OFF26_W = 28;

  logic [XLEN-1:0] seqPc;
  logic [XLEN-1:0] off16;
  logic [XLEN-1:0] off26;
  logic [XLEN-1:0] condTarget;
  logic [XLEN-1:0] relTarget;
  logic [XLEN-1:0] vecTarget;
  logic            cmpTrue;

  assign seqPc = pc + XLEN'(4);
  assign off16 = {{(XLEN-OFF16_W){immField[15]}}, immField[15:0], 2'b00};
  assign off26 = {{(XLEN-OFF26_W){immField[25]}}, immField[25:0], 2'b00};
  assign condTarget = pc + off16;
  assign relTarget  = pc + off26;
  assign vecTarget  = excBase + ({{(XLEN-3){1'b0}}, strobe.cause} << VEC_SHIFT);

  always_comb begin
    unique case (strobe.cmpOp)
      CMP_EQ:  cmpTrue = (opA == opB);
      CMP_GTS: cmpTrue = ($signed(opA) >  $signed(opB));
      CMP_GES: cmpTrue = ($signed(opA) >= $signed(opB));
      CMP_GEU: cmpTrue = (opA >= opB);
      CMP_GTU: cmpTrue = (opA >  opB);
      CMP_NE:  cmpTrue = (opA != opB);
      default: cmpTrue = 1'b0;
    endcase
  end

  always_comb begin
    unique case (strobe.pcSel)
      PS_HOLD:  nextPc = pc;
      PS_COND:  nextPc = cmpTrue ? condTarget : seqPc;
      PS_REL26: nextPc = relTarget;
      PS_REG:   nextPc = opA;
      PS_VEC:   nextPc = vecTarget;
      default:  nextPc = seqPc;
    endcase
  end

  assign linkWrEn = (strobe.linkSel != LK_NONE);
  assign linkIdx  = strobe.linkIdx;
  assign linkData = (strobe.linkSel == LK_RET) ? seqPc : pc;

endmodule

// File: rtl/npc_exc_unit.sv
module npc_exc_unit
  import npc_exc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int VEC_SHIFT = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instrValid,
  input  logic [XLEN-1:0] pc,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  logic [XLEN-1:0] excBase,
  input  logic            irqReq,
  input  logic            divZero,
  input  logic            csrIeWrEn,
  input  logic [2:0]      csrIeWrData,
  output logic [XLEN-1:0] nextPc,
  output logic            linkWrEn,
  output logic [4:0]      linkIdx,
  output logic [XLEN-1:0] linkData,
  output logic [2:0]      ieState,
  output logic            excTaken,
  output logic [2:0]      excCause
);

  strobe_t strobe;
  cause_e  causeCode;

  npc_exc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrValid (instrValid),
    .opcode     (instr[31:26]),
    .rsIdx      (instr[25:21]),
    .trapCode   (instr[4:0]),
    .pcLow      (pc[1:0]),
    .irqReq     (irqReq),
    .divZero    (divZero),
    .csrIeWrEn  (csrIeWrEn),
    .csrIeWrData(csrIeWrData),
    .strobe     (strobe),
    .ieState    (ieState),
    .excTaken   (excTaken),
    .excCause   (causeCode)
  );

  npc_exc_dpath #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT)) u_dpath (
    .pc       (pc),
    .immField (instr[25:0]),
    .opA      (opA),
    .opB      (opB),
    .excBase  (excBase),
    .strobe   (strobe),
    .nextPc   (nextPc),
    .linkWrEn (linkWrEn),
    .linkIdx  (linkIdx),
    .linkData (linkData)
  );

  assign excCause = causeCode;

endmodule

// File: rtl/npc_exc_checker.sv
module npc_exc_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instrValid,
  input logic [XLEN-1:0] pc,
  input logic [31:0]     instr,
  input logic            irqReq,
  input logic            csrIeWrEn,
  input logic [XLEN-1:0] nextPc,
  input logic            linkWrEn,
  input logic [4:0]      linkIdx,
  input logic [XLEN-1:0] linkData,
  input logic [2:0]      ieState,
  input logic            excTaken,
  input logic [2:0]      excCause
);

  logic [5:0] opc;
  assign opc = instr[31:26];

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && !excTaken && (opc == 6'd54 || opc == 6'd62))
      |-> (linkWrEn && linkIdx == 5'd29 && linkData == pc + XLEN'(4))); // R3

  AST_ERET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && !excTaken && !csrIeWrEn && opc == 6'd48 && instr[25:21] == 5'd30)
      |=> (ieState[0] == $past(ieState[1]) && ieState[2:1] == $past(ieState[2:1]))); // R4

  AST_EXC_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |-> (linkWrEn && linkData == pc)); // R6

  AST_EXC_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    excTaken |=> !ieState[0]); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && irqReq && !csrIeWrEn && !ieState[0]) |-> (excCause != 3'd1)); // R8

  AST_MISALIGN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && pc[1:0] != 2'b00) |-> (excTaken && excCause == 3'd6)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |-> (!linkWrEn && !excTaken && nextPc == pc)); // R12

endmodule

bind npc_exc_unit npc_exc_checker #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instrValid (instrValid),
  .pc         (pc),
  .instr      (instr),
  .irqReq     (irqReq),
  .csrIeWrEn  (csrIeWrEn),
  .nextPc     (nextPc),
  .linkWrEn   (linkWrEn),
  .linkIdx    (linkIdx),
  .linkData   (linkData),
  .ieState    (ieState),
  .excTaken   (excTaken),
  .excCause   (excCause)
);

// File: tb/npc_exc_unit_test.sv
`timescale 1ns/1ps
module npc_exc_unit_test;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instrValid = 1'b0;
  logic [31:0]     pc = '0;
  logic [31:0]     instr = '0;
  logic [31:0]     opA = '0;
  logic [31:0]     opB = '0;
  logic [31:0]     excBase = 32'h0000_8000;
  logic            irqReq = 1'b0;
  logic            divZero = 1'b0;
  logic            csrIeWrEn = 1'b0;
  logic [2:0]      csrIeWrData = '0;
  logic [31:0]     nextPc;
  logic            linkWrEn;
  logic [4:0]      linkIdx;
  logic [31:0]     linkData;
  logic [2:0]      ieState;
  logic            excTaken;
  logic [2:0]      excCause;

  int checks = 0;
  int fails  = 0;
  logic [2:0] ieModel = 3'b000;
  logic done = 1'b0;

  always #2 clk = ~clk;

  npc_exc_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .pc(pc), .instr(instr),
    .opA(opA), .opB(opB), .excBase(excBase), .irqReq(irqReq), .divZero(divZero),
    .csrIeWrEn(csrIeWrEn), .csrIeWrData(csrIeWrData), .nextPc(nextPc),
    .linkWrEn(linkWrEn), .linkIdx(linkIdx), .linkData(linkData),
    .ieState(ieState), .excTaken(excTaken), .excCause(excCause)
  );

  typedef struct {
    logic [31:0] npc;
    logic        lwr;
    logic [4:0]  lidx;
    logic [31:0] ldat;
    logic        exc;
    logic [2:0]  cz;
    logic [2:0]  ieN;
    string       tag;
  } exp_t;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic v, logic [31:0] p, logic [31:0] ins,
                                 logic [31:0] a, logic [31:0] b, logic [31:0] base,
                                 logic irq, logic dz, logic cw, logic [2:0] cwd,
                                 logic [2:0] ie);
    exp_t e;
    logic [2:0] ieS;
    int cz;
    int nsrc;
    logic [5:0] op;
    logic [31:0] o16, o26;
    logic tk;
    ieS   = cw ? cwd : ie;
    e.npc = p; e.lwr = 0; e.lidx = 0; e.ldat = 0; e.exc = 0; e.cz = 0;
    e.ieN = ieS; e.tag = cw ? "R11" : "R12";
    if (!v) return e;
    op  = ins[31:26];
    o16 = {{14{ins[15]}}, ins[15:0], 2'b00};
    o26 = {{4{ins[25]}}, ins[25:0], 2'b00};
    nsrc = 0;
    if (p[1:0] != 0) nsrc++;
    if (op == 43) nsrc++;
    if (dz) nsrc++;
    if (irq && ieS[0]) nsrc++;
    cz = 0;
    if (p[1:0] != 0) cz = 6;
    else if (op == 43 && ins[4:0] != 7 && ins[4:0] != 2) cz = 5;
    else if (dz) cz = 4;
    else if (op == 43) cz = (ins[4:0] == 7) ? 2 : 3;
    else if (irq && ieS[0]) cz = 1;
    if (cz != 0) begin
      e.exc = 1; e.cz = 3'(cz);
      e.npc = base + 32'(cz * 32);
      e.lwr = 1; e.ldat = p;
      e.lidx = (cz == 3) ? 5'd31 : 5'd30;
      if (cz == 3) e.ieN[2] = ieS[0]; else e.ieN[1] = ieS[0];
      e.ieN[0] = 1'b0;
      case (cz)
        6: e.tag = "R9";
        5, 2: e.tag = "R5";
        4: e.tag = "R7";
        1: e.tag = "R8";
        default: e.tag = "R6";
      endcase
      if (nsrc > 1) e.tag = "R10";
      return e;
    end
    case (op)
      17, 18, 19, 20, 21, 23: begin
        case (op)
          17: tk = (a == b);
          18: tk = ($signed(a) > $signed(b));
          19: tk = ($signed(a) >= $signed(b));
          20: tk = (a >= b);
          21: tk = (a > b);
          default: tk = (a != b);
        endcase
        e.npc = tk ? p + o16 : p + 4; e.tag = "R1";
      end
      56: begin e.npc = p + o26; e.tag = "R2"; end
      62: begin e.npc = p + o26; e.lwr = 1; e.lidx = 29; e.ldat = p + 4; e.tag = "R3"; end
      54: begin e.npc = a; e.lwr = 1; e.lidx = 29; e.ldat = p + 4; e.tag = "R3"; end
      48: begin
        e.npc = a; e.tag = "R4";
        if (ins[25:21] == 30) e.ieN[0] = ieS[1];
        else if (ins[25:21] == 31) e.ieN[0] = ieS[2];
      end
      default: begin e.npc = p + 4; e.tag = "R12"; end
    endcase
    return e;
  endfunction

  task automatic step(string note, logic v, logic [31:0] p, logic [31:0] ins,
                      logic [31:0] a, logic [31:0] b, logic irq, logic dz,
                      logic cw, logic [2:0] cwd);
    exp_t e;
    string t;
    @(negedge clk);
    instrValid = v; pc = p; instr = ins; opA = a; opB = b;
    irqReq = irq; divZero = dz; csrIeWrEn = cw; csrIeWrData = cwd;
    e = model(v, p, ins, a, b, excBase, irq, dz, cw, cwd, ieModel);
    t = (note == "") ? e.tag : {note, "/", e.tag};
    #1;
    check(t, "nextPc", nextPc, e.npc);
    check(t, "linkWrEn", {31'b0, linkWrEn}, {31'b0, e.lwr});
    if (e.lwr) begin
      check(t, "linkIdx", {27'b0, linkIdx}, {27'b0, e.lidx});
      check(t, "linkData", linkData, e.ldat);
    end
    check(t, "excTaken", {31'b0, excTaken}, {31'b0, e.exc});
    check(t, "excCause", {29'b0, excCause}, {29'b0, e.cz});
    @(posedge clk);
    #1;
    check(t, "ieState", {29'b0, ieState}, {29'b0, e.ieN});
    ieModel = e.ieN;
  endtask

  function automatic logic [31:0] mk(int op, int rs, int rt, int low16);
    return {6'(op), 5'(rs), 5'(rt), 16'(low16)};
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R13", "ieState after reset", {29'b0, ieState}, 32'd0);
    rst_n = 1'b1;
    ieModel = 3'b000;

    // R12 idle cycle, R13 state kept
    step("R12", 0, 32'h100, mk(17, 1, 1, 4), 0, 0, 1, 1, 0, 0);
    // R8 interrupt masked while IE is 0
    step("R8", 1, 32'h200, mk(13, 0, 0, 0), 0, 0, 1, 0, 0, 0);
    // R11 CSR write enables, interrupt in the same cycle is taken
    step("R11", 1, 32'h204, mk(13, 0, 0, 0), 0, 0, 1, 0, 1, 3'b001);
    // R11 + R4 CSR sets only EIE while return through r30 runs
    step("R11", 1, 32'h300, mk(48, 30, 0, 0), 32'h440, 0, 0, 0, 1, 3'b010);
    // R4 return through r31 with BIE clear
    step("R4", 1, 32'h304, mk(48, 31, 0, 0), 32'h500, 0, 0, 0, 0, 0);
    // R6 break trap copies IE into BIE
    step("R6", 1, 32'h400, mk(43, 0, 0, 2), 0, 0, 0, 0, 1, 3'b001);
    // R5 syscall trap
    step("R5", 1, 32'h404, mk(43, 0, 0, 7), 0, 0, 0, 0, 0, 0);
    // R5 illegal trap code, also beats divide-by-zero (R10)
    step("R5", 1, 32'h408, mk(43, 0, 0, 9), 0, 0, 0, 1, 0, 0);
    // R9 misaligned with syscall and interrupt present
    step("R9", 1, 32'h40e, mk(43, 0, 0, 7), 0, 0, 1, 0, 1, 3'b001);
    // R7 divide by zero
    step("R7", 1, 32'h500, mk(13, 0, 0, 0), 0, 0, 0, 1, 0, 0);
    // R1 backward branch, equal operands
    step("R1", 1, 32'h1000, mk(17, 1, 2, 16'hffff), 32'd5, 32'd5, 0, 0, 0, 0);
    // R1 signed vs unsigned greater
    step("R1", 1, 32'h1000, mk(18, 1, 2, 16'h0010), 32'hffff_ffff, 32'd1, 0, 0, 0, 0);
    step("R1", 1, 32'h1000, mk(21, 1, 2, 16'h0010), 32'hffff_ffff, 32'd1, 0, 0, 0, 0);
    // R2 negative relative jump
    step("R2", 1, 32'h2000, {6'd56, 26'h3ff_fffe}, 0, 0, 0, 0, 0, 0);
    // R3 both call forms
    step("R3", 1, 32'h2100, {6'd62, 26'h000_0040}, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 32'h2200, mk(54, 3, 0, 0), 32'h0000_7770, 0, 0, 0, 0, 0);

    for (int i = 0; i < 1500; i++) begin
      int sel;
      int opv;
      logic [31:0] ins, a, b, p;
      sel = $urandom_range(0, 11);
      case (sel)
        0: opv = 17; 1: opv = 18; 2: opv = 19; 3: opv = 20; 4: opv = 21;
        5: opv = 23; 6: opv = 43; 7: opv = 48; 8: opv = 54; 9: opv = 56;
        10: opv = 62; default: opv = 13;
      endcase
      ins = $urandom;
      ins[31:26] = 6'(opv);
      if (opv == 48 && $urandom_range(0, 1) == 1) ins[25:21] = ($urandom_range(0, 1) == 1) ? 5'd30 : 5'd31;
      if (opv == 43 && $urandom_range(0, 3) != 0) ins[4:0] = ($urandom_range(0, 1) == 1) ? 5'd7 : 5'd2;
      a = $urandom; b = $urandom;
      if ($urandom_range(0, 3) == 0) b = a;
      p = {$urandom_range(0, 32'h0fff_ffff), 2'b00};
      if ($urandom_range(0, 19) == 0) p[1:0] = 2'($urandom_range(1, 3));
      step("", $urandom_range(0, 9) != 0, p, ins, a, b,
           $urandom_range(0, 4) == 0, $urandom_range(0, 19) == 0,
           $urandom_range(0, 6) == 0, 3'($urandom_range(0, 7)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule